// File: doc/BRIEF.md
# Masked Prioritized Interrupt Code Encoder

This block gathers the interrupt requests of fifteen CAN message buffers into one small binary code. Each buffer owns a pending flag. The flag is raised by a one-cycle set event and stays high until a one-cycle clear strobe for that buffer arrives. A separate code-enable mask, which software rewrites through a simple write port, selects which pending flags take part in encoding. The mask is independent of the interrupt enables.

The block presents a 4-bit code that names the enabled pending buffer of highest priority. Buffer 0 has the highest priority, and the code equals the buffer index plus one. A handler can add the code to a table base and jump straight to the service routine. A code of zero, together with a low aggregate flag, means that no enabled request waits.

The mask lets a handler work through one group at a time. For example, it can enable only the receive buffers and service them, then enable only the transmit buffers and service those. Requests outside the current group stay pending throughout.

Top module: `irq_code_enc`

## Requirements
- R1: After reset every pending flag is clear, every mask bit is one (all buffers included), `code_o` is 0 and `any_o` is 0.
- R2: A high `set_i[i]` at a clock edge makes pending flag i high after that edge, and the flag stays high on later cycles until it is cleared.
- R3: A high `clr_i[i]` at a clock edge clears pending flag i, unless `set_i[i]` is also high at that same edge, in which case the flag stays high.
- R4: `code_o` equals i+1, where i is the lowest index whose pending flag and mask bit are both one; `code_o` is 0 when no such index exists.
- R5: `any_o` is 1 exactly when `code_o` is nonzero.
- R6: A high `mask_we_i` at a clock edge loads `mask_wdata_i` into the mask, where bit i = 1 includes buffer i in the encoding; without `mask_we_i` the mask keeps its value.
- R7: Masking a buffer does not clear its pending flag; once its mask bit is set again, the buffer is encoded again.
- R8: Among several enabled pending buffers, the lower index always wins, whatever the order in which their requests arrived.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| set_i | input | 15 | Per-buffer pending set events, one cycle each |
| clr_i | input | 15 | Per-buffer pending clear strobes, one cycle each |
| mask_we_i | input | 1 | Write strobe for the code-enable mask |
| mask_wdata_i | input | 15 | New code-enable mask value, bit i for buffer i |
| code_o | output | 4 | Index plus one of the winning buffer; 0 when none |
| any_o | output | 1 | High when any enabled request is pending |

## Verification
Some rules are checked by the embedded properties on every cycle. They cover the set-over-clear rule on the pending flags and the loading and holding of the mask. They also check that the code always points at an enabled pending buffer with no enabled pending buffer below it, that the aggregate flag agrees with the code, and that a mask write alone never drops a pending flag. Some behaviour only the bench scenarios can show: the reset value of the mask, a masked request coming back once it is re-enabled, the group-by-group servicing sequence, and the full sweep of codes 1 to 15 for single requests.

// File: rtl/icode_pkg.sv
package icode_pkg;
    localparam int unsigned NBUF_DEF = 15;

    function automatic int unsigned code_width(input int unsigned nbuf);
        return $clog2(nbuf + 1);
    endfunction
endpackage

// File: rtl/icode_pend_bank.sv
module icode_pend_bank #(
    parameter int unsigned NBUF = icode_pkg::NBUF_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NBUF-1:0] set_i,
    input  logic [NBUF-1:0] clr_i,
    output logic [NBUF-1:0] pend_o
);
    logic [NBUF-1:0] pend_q;

    // Set has precedence over a clear arriving in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= (pend_q & ~clr_i) | set_i;
        end
    end

    assign pend_o = pend_q;

    assert_set_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((pend_q & $past(set_i)) == $past(set_i)));

    assert_clear_takes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_i & ~set_i) != '0) |=> ((pend_q & $past(clr_i & ~set_i)) == '0));

    assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i == '0) |=> ((pend_q & $past(pend_q)) == $past(pend_q)));
endmodule

// File: rtl/icode_mask_reg.sv
module icode_mask_reg #(
    parameter int unsigned NBUF = icode_pkg::NBUF_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we_i,
    input  logic [NBUF-1:0] wdata_i,
    output logic [NBUF-1:0] mask_o
);
    logic [NBUF-1:0] mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '1;
        end else if (we_i) begin
            mask_q <= wdata_i;
        end
    end

    assign mask_o = mask_q;

    assert_mask_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (mask_q == $past(wdata_i)));

    assert_mask_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(mask_q));
endmodule

// File: rtl/icode_prio_coder.sv
module icode_prio_coder #(
    parameter int unsigned NBUF = icode_pkg::NBUF_DEF,
    localparam int unsigned CW = icode_pkg::code_width(NBUF)
) (
    input  logic [NBUF-1:0] req_i,
    output logic [CW-1:0]   code_o,
    output logic            any_o
);
    logic [NBUF:0]   seen;
    logic [NBUF-1:0] hit;

    assign seen[0] = 1'b0;

    for (genvar g = 0; g < NBUF; g++) begin : g_chain
        assign hit[g]      = req_i[g] & ~seen[g];
        assign seen[g + 1] = seen[g] | req_i[g];
    end

    always_comb begin
        code_o = '0;
        for (int i = 0; i < NBUF; i++) begin
            if (hit[i]) begin
                code_o = code_o | CW'(i + 1);
            end
        end
    end

    assign any_o = seen[NBUF];

    always_comb begin
        assert_single_winner_R8: assert ($onehot0(hit));
    end
endmodule

// File: rtl/irq_code_enc.sv
module irq_code_enc #(
    parameter int unsigned NBUF = icode_pkg::NBUF_DEF,
    localparam int unsigned CW = icode_pkg::code_width(NBUF)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NBUF-1:0] set_i,
    input  logic [NBUF-1:0] clr_i,
    input  logic            mask_we_i,
    input  logic [NBUF-1:0] mask_wdata_i,
    output logic [CW-1:0]   code_o,
    output logic            any_o
);
    logic [NBUF-1:0] pend;
    logic [NBUF-1:0] mask;
    logic [NBUF-1:0] masked;

    icode_pend_bank #(.NBUF(NBUF)) pend_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_i),
        .clr_i  (clr_i),
        .pend_o (pend)
    );

    icode_mask_reg #(.NBUF(NBUF)) mask_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (mask_we_i),
        .wdata_i (mask_wdata_i),
        .mask_o  (mask)
    );

    assign masked = pend & mask;

    icode_prio_coder #(.NBUF(NBUF)) coder_i (
        .req_i  (masked),
        .code_o (code_o),
        .any_o  (any_o)
    );

    // One-hot image of the buffer named by the code, used by the checks.
    logic [NBUF-1:0] win_bit;
    always_comb begin
        win_bit = '0;
        if (code_o != '0) begin
            win_bit = NBUF'(1) << (code_o - CW'(1));
        end
    end

    assert_code_points_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (code_o != '0) |-> ((masked & win_bit) != '0));

    assert_lowest_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (code_o != '0) |-> ((masked & (win_bit - NBUF'(1))) == '0));

    assert_zero_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (code_o == '0) |-> (masked == '0));

    assert_any_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
        any_o == (code_o != '0));

    assert_mask_keeps_pend_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_we_i && clr_i == '0) |=> ((pend & $past(pend)) == $past(pend)));
endmodule

// File: tb/irq_code_enc_tb_top.sv
module irq_code_enc_tb_top;
    localparam int NB = 15;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NB-1:0] set_i = '0;
    logic [NB-1:0] clr_i = '0;
    logic          mask_we_i = 1'b0;
    logic [NB-1:0] mask_wdata_i = '0;
    logic [CW-1:0] code_o;
    logic          any_o;

    always #5 clk = ~clk;

    irq_code_enc dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .set_i        (set_i),
        .clr_i        (clr_i),
        .mask_we_i    (mask_we_i),
        .mask_wdata_i (mask_wdata_i),
        .code_o       (code_o),
        .any_o        (any_o)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference state kept from the requirements.
    logic [NB-1:0] pend_m = '0;
    logic [NB-1:0] mask_m = '1;

    logic [CW-1:0] exp_code_q[$];
    logic          exp_any_q[$];
    string         tag_q[$];

    function automatic logic [CW-1:0] ref_code(input logic [NB-1:0] p, input logic [NB-1:0] m);
        for (int i = 0; i < NB; i++) begin
            if (p[i] && m[i]) return CW'(i + 1);
        end
        return '0;
    endfunction

    task automatic step(input logic [NB-1:0] s, input logic [NB-1:0] c,
                        input logic we, input logic [NB-1:0] wd, input string tag);
        logic [CW-1:0] ec;
        @(negedge clk);
        set_i = s;
        clr_i = c;
        mask_we_i = we;
        mask_wdata_i = wd;
        pend_m = (pend_m & ~c) | s;
        if (we) mask_m = wd;
        ec = ref_code(pend_m, mask_m);
        exp_code_q.push_back(ec);
        exp_any_q.push_back(ec != '0);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input string tag);
        step('0, '0, 1'b0, '0, tag);
    endtask

    // Monitor: compare one expected item per cycle, shortly after the edge.
    always @(posedge clk) begin
        #1;
        if (exp_code_q.size() > 0) begin
            logic [CW-1:0] ec;
            logic          ea;
            string         t;
            ec = exp_code_q.pop_front();
            ea = exp_any_q.pop_front();
            t  = tag_q.pop_front();
            checks++;
            if (code_o !== ec || any_o !== ea) begin
                errors++;
                $display("FAIL %s: code=%0d any=%0b expected code=%0d any=%0b",
                         t, code_o, any_o, ec, ea);
            end
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state at the ports
        checks++;
        if (code_o !== '0 || any_o !== 1'b0) begin
            errors++;
            $display("FAIL R1: code=%0d any=%0b expected code=0 any=0", code_o, any_o);
        end
        @(negedge clk);
        rst_n = 1'b1;
        idle("R1 idle after reset");
        // R1: mask resets to all ones, so the lowest-priority buffer is coded
        step(15'h4000, '0, 1'b0, '0, "R1 mask all ones buffer 14");
        step('0, 15'h4000, 1'b0, '0, "R3 clear buffer 14");

        // R2: set and hold
        step(15'h0020, '0, 1'b0, '0, "R2 set buffer 5");
        idle("R2 buffer 5 held");
        idle("R2 buffer 5 held again");
        // R8: higher priority arrives later
        step(15'h0004, '0, 1'b0, '0, "R8 buffer 2 over 5");
        step(15'h0001, '0, 1'b0, '0, "R8 buffer 0 over 2");
        step(15'h0000, 15'h0001, 1'b0, '0, "R3 clear buffer 0");
        step(15'h0001, 15'h0001, 1'b0, '0, "R3 set and clear same cycle");
        step('0, 15'h0005, 1'b0, '0, "R3 clear buffers 0 and 2");
        step(15'h3000, '0, 1'b0, '0, "R4 add buffers 12 13");

        // R6/R7: code transmit group only, receive group stays pending
        step('0, '0, 1'b1, 15'h7C00, "R6 mask high group");
        step('0, 15'h1000, 1'b0, '0, "R6 service buffer 12");
        step('0, '0, 1'b1, 15'h0000, "R5 mask none any low");
        idle("R7 masked pending idle");
        step('0, '0, 1'b1, 15'h03FF, "R7 low group back");
        step('0, 15'h0020, 1'b0, '0, "R7 service buffer 5");
        step('0, '0, 1'b1, 15'h7FFF, "R7 reenable all");
        step('0, 15'h2000, 1'b0, '0, "R4 all serviced");

        // R6: masked set events stay hidden
        step('0, '0, 1'b1, 15'h0008, "R6 only buffer 3");
        step(15'h0002, '0, 1'b0, '0, "R6 masked buffer 1 hidden");
        step(15'h0008, '0, 1'b0, '0, "R6 buffer 3 coded");
        step('0, '0, 1'b1, 15'h7FFF, "R7 buffer 1 revealed");
        step('0, 15'h000A, 1'b0, '0, "R3 clear 1 and 3");

        // R4: sweep every single buffer
        for (int i = 0; i < NB; i++) begin
            step(NB'(1) << i, '0, 1'b0, '0, "R4 sweep single set");
            step('0, NB'(1) << i, 1'b0, '0, "R4 sweep clear");
        end
        // R8: all pending, retire from the top
        step('1, '0, 1'b0, '0, "R8 all pending");
        for (int i = 0; i < NB; i++) begin
            step('0, NB'(1) << i, 1'b0, '0, "R8 retire lowest");
        end
        idle("R5 final idle");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule